// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous on-chip logic read and write an external asynchronous static RAM that holds one million bytes. A client offers one access at a time on a valid/ready port: a 20-bit address, a byte of write data and a direction flag. Reads return their byte with a one-cycle valid pulse. On the memory side the controller drives active-low select, output-enable and write-strobe pins, the address bus, a data-out bus and an enable for the data-out drivers. It samples a data-in bus. The pad tristate buffers sit outside the block.

Every memory timing limit is turned into a whole number of clock cycles. The strobe low phase, the read access wait and the turnaround gap are each given as picosecond parameters, and each becomes a cycle count rounded up from the clock period, never below one. The write window is the overlap of select low and strobe low. It is framed by one select-only cycle on each side. During that time the data drivers stay on and the output enable stays high. This allows the shorter strobe width and keeps the memory's outputs off the bus. Between accesses all pins are high and the drivers are off, which leaves the memory in standby.

Top module: `xsram_ctrl`

## Requirements
- R1: Under reset and while idle, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1, and only one access runs at a time. From the next cycle req_ready stays 0 for 2+W+T cycles on a write and R+T cycles on a read. W, R and T are the strobe, access and turnaround cycle counts. Each accepted request gives exactly one falling edge of mem_ce_n.
- R3: A write drives mem_we_n low for exactly W consecutive cycles, starting in the second cycle after acceptance. mem_ce_n is low for those cycles and for one cycle before and one cycle after them, and mem_we_n is never low while mem_ce_n is high.
- R4: mem_oe_n stays 1 for the whole of every write access and is never 0 while mem_we_n is 0.
- R5: On a write, mem_dq_oe is 1 and mem_dq_out holds the request's byte from the cycle before mem_we_n falls through the cycle after it rises. mem_dq_oe is 0 at all other times and is never 1 while mem_oe_n is 0.
- R6: A read holds mem_ce_n and mem_oe_n low and mem_we_n high for exactly R cycles starting in the cycle after acceptance. mem_dq_in is sampled at the clock edge that ends the last of those cycles.
- R7: A read raises rsp_valid for exactly one cycle, the cycle after its last access cycle (R cycles after the acceptance edge), with rsp_rdata equal to the sampled byte. A write never raises rsp_valid.
- R8: mem_addr takes the request address at the acceptance edge and holds it unchanged for the whole access and until the next acceptance.
- R9: After every access mem_ce_n is 1 and mem_dq_oe is 0 for T cycles before req_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client offers an access |
| req_ready | output | 1 | Controller can take an access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Byte returned by a read |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 20 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-out pad drivers |
| mem_dq_in | input | 8 | Data sampled from the memory |

## Verification
The bench builds the controller for a 8000 ps clock, with a 20000 ps strobe, a 10000 ps access and a 12000 ps turnaround. This gives three strobe cycles, two access cycles and two turnaround cycles. Because every timer runs past its first count, a counter that stops early or late shows up as a wrong strobe width, response cycle or ready gap. A small memory model answers reads and commits writes when the strobe rises. Written bytes therefore come back only if data was held across the ending edge. Addresses at both ends of the 20-bit range, back-to-back reads and writes, and a request held across a busy period are all covered.

// File: rtl/xsram_pkg.sv
package xsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RWAIT,
        ST_TURN
    } xs_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } xs_pins_t;

    localparam xs_pins_t PINS_STANDBY = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    localparam xs_pins_t PINS_WFRAME  = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
    localparam xs_pins_t PINS_WSTROBE = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
    localparam xs_pins_t PINS_READ    = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};

    // Whole cycles needed to cover a limit, never fewer than one.
    function automatic int cycles_for(input int need_ps, input int clk_ps);
        int c;
        c = (need_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/xsram_timer.sv
module xsram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/xsram_fsm.sv
module xsram_fsm
    import xsram_pkg::*;
#(
    parameter int WE_CYC   = 1,
    parameter int RD_CYC   = 1,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output xs_pins_t         pins
);

    localparam logic [CNT_W-1:0] WE_LOAD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    typedef struct packed {
        xs_state_e st;
        xs_pins_t  pins;
        logic      ready;
    } fsm_regs_t;

    fsm_regs_t d, q;

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && q.ready) begin
                    accept  = 1'b1;
                    d.ready = 1'b0;
                    if (req_write) begin
                        d.st   = ST_WSETUP;
                        d.pins = PINS_WFRAME;
                    end else begin
                        d.st     = ST_RWAIT;
                        d.pins   = PINS_READ;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_WSETUP: begin
                d.st     = ST_WPULSE;
                d.pins   = PINS_WSTROBE;
                tmr_load = 1'b1;
                tmr_val  = WE_LOAD;
            end
            ST_WPULSE: begin
                if (tmr_last) begin
                    d.st   = ST_WHOLD;
                    d.pins = PINS_WFRAME;
                end
            end
            ST_WHOLD: begin
                d.st     = ST_TURN;
                d.pins   = PINS_STANDBY;
                tmr_load = 1'b1;
                tmr_val  = TURN_LOAD;
            end
            ST_RWAIT: begin
                if (tmr_last) begin
                    capture  = 1'b1;
                    d.st     = ST_TURN;
                    d.pins   = PINS_STANDBY;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LOAD;
                end
            end
            ST_TURN: begin
                if (tmr_last) begin
                    d.st    = ST_IDLE;
                    d.ready = 1'b1;
                end
            end
            default: begin
                d.st    = ST_IDLE;
                d.pins  = PINS_STANDBY;
                d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.pins  <= PINS_STANDBY;
            q.ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready = q.ready;
    assign pins  = q.pins;

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pins.ce_n && pins.we_n && !pins.drive)); // R1
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.we_n |-> !pins.ce_n); // R3
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WPULSE && !tmr_last) |=> (q.st == ST_WPULSE && !pins.we_n)); // R3
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.we_n |-> pins.oe_n); // R4
    AST_NO_DRIVE_INTO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pins.drive |-> pins.oe_n); // R5
    AST_DRIVE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins.we_n) |-> $past(pins.drive)); // R5
    AST_DRIVE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins.we_n) |-> (pins.drive && !pins.ce_n)); // R5
    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TURN) |-> (pins.ce_n && !pins.drive && !ready)); // R9

endmodule

// File: rtl/xsram_dpath.sv
module xsram_dpath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } dp_regs_t;

    dp_regs_t d, q;

    always_comb begin
        d        = q;
        d.rvalid = capture;
        if (accept) begin
            d.addr  = req_addr;
            d.wdata = req_wdata;
        end
        if (capture) begin
            d.rdata = mem_dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr   = q.addr;
    assign mem_dq_out = q.wdata;
    assign rsp_valid  = q.rvalid;
    assign rsp_rdata  = q.rdata;

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7

endmodule

// File: rtl/xsram_ctrl.sv
module xsram_ctrl
    import xsram_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 8,
    parameter int CLK_PS       = 10000,
    parameter int STROBE_PS    = 8000,
    parameter int ACCESS_PS    = 10000,
    parameter int TURNAROUND_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int WE_CYC   = cycles_for(STROBE_PS, CLK_PS);
    localparam int RD_CYC   = cycles_for(ACCESS_PS, CLK_PS);
    localparam int TURN_CYC = cycles_for(TURNAROUND_PS, CLK_PS);
    localparam int MAX_CYC  = (WE_CYC > RD_CYC) ?
                              ((WE_CYC > TURN_CYC) ? WE_CYC : TURN_CYC) :
                              ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             accept;
    logic             capture;
    xs_pins_t         pins;

    xsram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    xsram_fsm #(
        .WE_CYC   (WE_CYC),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .pins      (pins)
    );

    xsram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drive;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr)); // R8
    AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n)); // R7

endmodule

// File: tb/xsram_ctrl_test.sv
`timescale 1ns/1ps
module xsram_ctrl_test;

    // Expected cycle counts for the bench parameters (8000 ps clock).
    localparam int W = 3;  // 20000 ps strobe
    localparam int R = 2;  // 10000 ps access
    localparam int T = 2;  // 12000 ps turnaround

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [19:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_checks = 0;
    int n_err = 0;
    int ce_falls = 0;
    int accesses = 0;
    int clash = 0;
    logic [7:0] model [0:1023];
    logic [7:0] expect_mem [int];

    always #4 clk = ~clk;

    xsram_ctrl #(
        .CLK_PS(8000), .STROBE_PS(20000), .ACCESS_PS(10000), .TURNAROUND_PS(12000)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: answers while selected with outputs on, commits on strobe rise.
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr[9:0]] : 8'hA5;

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_dq_oe) model[mem_addr[9:0]] = mem_dq_out;
    end

    always @(negedge mem_ce_n) if (rst_n) ce_falls++;

    always @(negedge clk) begin
        if (rst_n && ((mem_dq_oe && !mem_oe_n) || (!mem_we_n && !mem_oe_n))) clash++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    task automatic start_req(input bit wr, input logic [19:0] a, input logic [7:0] v);
        @(negedge clk);
        req_write = wr;
        req_addr  = a;
        req_wdata = v;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        accesses++;
    endtask

    task automatic do_write(input logic [19:0] a, input logic [7:0] v);
        int we_low = 0;
        int first_low = -1;
        bit oe_ok = 1, drv_ok = 1, rdy_ok = 1, turn_ok = 1, addr_ok = 1, rsp_ok = 1;
        start_req(1'b1, a, v);
        for (int k = 0; k < 2 + W + T + 1; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (!mem_we_n) begin
                we_low++;
                if (first_low < 0) first_low = k;
            end
            if (k <= W + 1) begin
                if (!mem_oe_n) oe_ok = 0;
                if (mem_addr !== a) addr_ok = 0;
                if (mem_dq_oe !== 1'b1 || mem_dq_out !== v || mem_ce_n !== 1'b0) drv_ok = 0;
            end else begin
                if (mem_dq_oe !== 1'b0) drv_ok = 0;
            end
            if ((k >= W + 2) && (k < W + 2 + T) && (mem_ce_n !== 1'b1)) turn_ok = 0;
            if (req_ready !== (k == 2 + W + T)) rdy_ok = 0;
            if (rsp_valid) rsp_ok = 0;
        end
        expect_mem[a] = v;
        check(we_low == W && first_low == 1, "R3", "strobe low cycles", we_low, W);
        check(oe_ok, "R4", "output enable high in write", oe_ok, 1);
        check(drv_ok, "R5", "data drive window", drv_ok, 1);
        check(rdy_ok, "R2", "write busy span", rdy_ok, 1);
        check(turn_ok, "R9", "write turnaround", turn_ok, 1);
        check(addr_ok, "R8", "write address held", addr_ok, 1);
        check(rsp_ok, "R7", "no response on write", rsp_ok, 1);
    endtask

    task automatic do_read(input logic [19:0] a);
        bit acc_ok = 1, rdy_ok = 1, turn_ok = 1, addr_ok = 1, drv_ok = 1;
        int pulses = 0;
        int pulse_at = -1;
        logic [7:0] got = 8'h00;
        logic [7:0] exp = expect_mem.exists(a) ? expect_mem[a] : 8'h00;
        start_req(1'b0, a, 8'h00);
        for (int k = 0; k < R + T + 1; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (k < R) begin
                if (mem_ce_n !== 1'b0 || mem_oe_n !== 1'b0 || mem_we_n !== 1'b1) acc_ok = 0;
                if (mem_addr !== a) addr_ok = 0;
            end else if (mem_oe_n !== 1'b1) acc_ok = 0;
            if (k >= R && k < R + T && mem_ce_n !== 1'b1) turn_ok = 0;
            if (mem_dq_oe !== 1'b0) drv_ok = 0;
            if (req_ready !== (k == R + T)) rdy_ok = 0;
            if (rsp_valid) begin
                pulses++;
                pulse_at = k;
                got = rsp_rdata;
            end
        end
        check(acc_ok, "R6", "read strobe window", acc_ok, 1);
        check(pulses == 1 && pulse_at == R, "R7", "response pulse cycle", pulse_at, R);
        check(got == exp, "R7", "read data", got, exp);
        check(rdy_ok, "R2", "read busy span", rdy_ok, 1);
        check(turn_ok, "R9", "read turnaround", turn_ok, 1);
        check(addr_ok, "R8", "read address held", addr_ok, 1);
        check(drv_ok, "R5", "no drive during read", drv_ok, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "pins in reset",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1", "ready after reset",
              {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic test_held_request();
        // Valid stays high while the first read is busy; the second must start once.
        int falls0 = ce_falls;
        start_req(1'b0, 20'h00155, 8'h00);
        repeat (R + T) @(negedge clk);
        req_addr = 20'hFFFFF;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        accesses++;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (R + T + 2) @(negedge clk);
        check(ce_falls - falls0 == 2, "R2", "one select per accepted request",
              ce_falls - falls0, 2);
        check(mem_addr == 20'hFFFFF, "R8", "address kept after access", mem_addr, 20'hFFFFF);
    endtask

    task automatic test_standby();
        repeat (5) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1",
              "idle standby", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        check(clash == 0, "R4", "no drive or strobe with outputs on", clash, 0);
        check(ce_falls == accesses, "R2", "select count", ce_falls, accesses);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        test_reset();
        do_write(20'h00000, 8'h3C);
        do_write(20'hFFFFF, 8'hC3);
        do_write(20'h12345, 8'h5A);
        do_read(20'h00000);
        do_read(20'hFFFFF);
        do_read(20'h12345);
        do_write(20'h12345, 8'hA7);
        do_read(20'h12345);
        do_read(20'h00155);
        do_write(20'h00155, 8'hFF);
        do_read(20'h00155);
        test_held_request();
        test_standby();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        report();
    end

endmodule